// File: doc/BRIEF.md
# Receive Flow-Control Pin Driver

This block drives the two active-low modem-control outputs of a serial receiver, a request-to-send pin and a terminal-ready pin. One of the two pins can be handed to hardware. That pin then tells the far-end transmitter to pause when the local receive FIFO fills and to resume once the FIFO drains. The block watches the FIFO fill count and applies hysteresis between two thresholds. The pause threshold lies above the programmed trigger level and the resume threshold lies below it, so the pin does not chatter around a single level.

The thresholds come from one of three fixed four-entry trigger tables, or from a programmable level widened by a coded hysteresis band. Software turns on automatic control with an enable bit. Automatic control then starts only once software also asserts the chosen pin's own control bit. Whenever automatic control is off, each pin simply mirrors its software bit. All outputs are registered.

Top module: `rx_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, both `rts_n` and `dtr_n` are HIGH (deasserted).
- R2: With `use_dtr`=0 the hardware manages `rts_n` (software bit `sw_rts`); with `use_dtr`=1 it manages `dtr_n` (software bit `sw_dtr`). The pin that is not managed always equals the inverse of its own software bit.
- R3: With `flow_en`=0, `rts_n` = NOT `sw_rts` and `dtr_n` = NOT `sw_dtr`, whatever the fill count.
- R4: With `flow_en`=1 and the managed pin's software bit at 0, the managed pin is HIGH at every fill count. Raising that bit starts automatic control afresh: the pin goes LOW unless the fill count is at or above the pause threshold.
- R5: Fixed tables are selected by `table_sel` 0, 1 and 2, with levels {8,16,56,60}, {16,32,48,56} and {8,16,32,56}; `trig_idx` 0..3 picks the programmed entry. Under automatic control the pin goes HIGH when the fill count is greater than or equal to the entry at `trig_idx`+1. The pin stays LOW at the programmed level itself.
- R6: Once HIGH, the pin returns LOW when the fill count is less than or equal to the entry at `trig_idx`-1. Strictly between the two thresholds it keeps its previous value.
- R7: At `trig_idx`=3 the pause threshold is the FIFO depth (64). At `trig_idx`=0 the resume threshold is 0.
- R8: `table_sel`=3 selects programmable mode with band h = 4 × `hyst_code`. The pause threshold is min(`prog_level`+h, 64) and the resume threshold is max(min(`prog_level`,64)−h, 0). Pausing takes precedence when both apply, so `hyst_code`=0 pauses at `prog_level` and resumes below it.
- R9: Every output is registered. A change on any input shows at the pins one rising clock edge later and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_count | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| table_sel | input | 2 | 0..2 fixed table, 3 programmable |
| trig_idx | input | 2 | Programmed entry within a fixed table |
| prog_level | input | 7 | Programmed trigger level in programmable mode |
| hyst_code | input | 4 | Hysteresis band code, band = 4 × code entries |
| flow_en | input | 1 | Enables automatic flow control |
| use_dtr | input | 1 | 0: manage request-to-send, 1: manage terminal-ready |
| sw_rts | input | 1 | Software assert bit for `rts_n` |
| sw_dtr | input | 1 | Software assert bit for `dtr_n` |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |

## Verification
Each pin result is due exactly one rising edge after the inputs that cause it, because a single register stage sits between the inputs and the pins. The bench therefore changes inputs just after a falling edge and compares the pins at the following falling edge. For the latency requirement it also samples the pins one nanosecond after an input change, before any edge, and expects the old value there. The bench keeps its own model of the paused state and its own threshold arithmetic, and it updates both once per edge. Ramping the fill count from 0 to 64 and back checks every crossing of both thresholds for every table entry and for several programmable levels and band codes.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    localparam int LEVELS = 4;
    localparam int IDX_W  = 2;
    localparam int HYST_W = 4;
    localparam int LVL_W  = 8;

    typedef struct packed {
        logic paused;
        logic rts_n;
        logic dtr_n;
    } rfc_state_t;
endpackage

// File: rtl/rfc_fixed_thresh.sv
module rfc_fixed_thresh
    import rfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7,
    parameter int NUM_TABLES = 3,
    parameter int TSEL_W     = 2,
    parameter logic [0:NUM_TABLES-1][0:LEVELS-1][LVL_W-1:0] TRIG_LEVELS =
        '{'{8'd8, 8'd16, 8'd56, 8'd60},
          '{8'd16, 8'd32, 8'd48, 8'd56},
          '{8'd8, 8'd16, 8'd32, 8'd56}}
) (
    input  logic [TSEL_W-1:0] table_sel,
    input  logic [IDX_W-1:0]  trig_idx,
    output logic [CNT_W-1:0]  pause_th,
    output logic [CNT_W-1:0]  resume_th
);
    logic [NUM_TABLES-1:0][CNT_W-1:0] p_tab;
    logic [NUM_TABLES-1:0][CNT_W-1:0] r_tab;

    // One neighbour lookup per table (R5, R6); the ends clamp (R7).
    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tab
        logic [CNT_W-1:0] p_l;
        logic [CNT_W-1:0] r_l;
        always_comb begin
            p_l = CNT_W'(FIFO_DEPTH);
            r_l = '0;
            for (int i = 0; i < LEVELS; i++) begin
                if (trig_idx == IDX_W'(i)) begin
                    if (i < LEVELS - 1)
                        p_l = CNT_W'(TRIG_LEVELS[t][(i < LEVELS - 1) ? i + 1 : i]);
                    if (i > 0)
                        r_l = CNT_W'(TRIG_LEVELS[t][(i > 0) ? i - 1 : 0]);
                end
            end
        end
        assign p_tab[t] = p_l;
        assign r_tab[t] = r_l;
    end

    always_comb begin
        pause_th  = p_tab[0];
        resume_th = r_tab[0];
        for (int t = 1; t < NUM_TABLES; t++) begin
            if (table_sel == TSEL_W'(t)) begin
                pause_th  = p_tab[t];
                resume_th = r_tab[t];
            end
        end
    end
endmodule

// File: rtl/rfc_prog_thresh.sv
module rfc_prog_thresh
    import rfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7,
    parameter int HYST_STEP  = 4
) (
    input  logic [CNT_W-1:0]  prog_level,
    input  logic [HYST_W-1:0] hyst_code,
    output logic [CNT_W-1:0]  pause_th,
    output logic [CNT_W-1:0]  resume_th
);
    localparam int SUM_W = CNT_W + HYST_W + 4;

    logic [SUM_W-1:0] band;
    logic [SUM_W-1:0] upper;
    logic [SUM_W-1:0] base;

    // R8: band around the programmed level, clamped to 0..depth
    always_comb begin
        band  = SUM_W'(hyst_code) * SUM_W'(HYST_STEP);
        upper = SUM_W'(prog_level) + band;
        base  = (SUM_W'(prog_level) > SUM_W'(FIFO_DEPTH)) ? SUM_W'(FIFO_DEPTH)
                                                         : SUM_W'(prog_level);
        pause_th  = (upper > SUM_W'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH) : CNT_W'(upper);
        resume_th = (base > band) ? CNT_W'(base - band) : '0;
    end
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
    import rfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int NUM_TABLES = 3,
    parameter int HYST_STEP  = 4,
    parameter logic [0:NUM_TABLES-1][0:LEVELS-1][LVL_W-1:0] TRIG_LEVELS =
        '{'{8'd8, 8'd16, 8'd56, 8'd60},
          '{8'd16, 8'd32, 8'd48, 8'd56},
          '{8'd8, 8'd16, 8'd32, 8'd56}}
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]    fill_count,
    input  logic [$clog2(NUM_TABLES+1)-1:0]    table_sel,
    input  logic [IDX_W-1:0]                   trig_idx,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]    prog_level,
    input  logic [HYST_W-1:0]                  hyst_code,
    input  logic                               flow_en,
    input  logic                               use_dtr,
    input  logic                               sw_rts,
    input  logic                               sw_dtr,
    output logic                               rts_n,
    output logic                               dtr_n
);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int TSEL_W = $clog2(NUM_TABLES + 1);

    logic [CNT_W-1:0] fx_pause, fx_resume;
    logic [CNT_W-1:0] pg_pause, pg_resume;
    logic [CNT_W-1:0] pause_th, resume_th;
    logic             prog_mode;
    logic             mgd_sw;
    logic             auto_on;
    rfc_state_t       st_d, st_q;

    rfc_fixed_thresh #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W),
        .NUM_TABLES (NUM_TABLES),
        .TSEL_W     (TSEL_W),
        .TRIG_LEVELS(TRIG_LEVELS)
    ) u_fixed (
        .table_sel(table_sel),
        .trig_idx (trig_idx),
        .pause_th (fx_pause),
        .resume_th(fx_resume)
    );

    rfc_prog_thresh #(
        .FIFO_DEPTH(FIFO_DEPTH),
        .CNT_W     (CNT_W),
        .HYST_STEP (HYST_STEP)
    ) u_prog (
        .prog_level(prog_level),
        .hyst_code (hyst_code),
        .pause_th  (pg_pause),
        .resume_th (pg_resume)
    );

    assign prog_mode = (table_sel >= TSEL_W'(NUM_TABLES));
    assign pause_th  = prog_mode ? pg_pause  : fx_pause;
    assign resume_th = prog_mode ? pg_resume : fx_resume;

    always_comb begin
        st_d    = st_q;
        mgd_sw  = use_dtr ? sw_dtr : sw_rts;          // R2
        auto_on = flow_en & mgd_sw;                   // R3, R4
        if (!auto_on)
            st_d.paused = 1'b0;                       // fresh start (R4)
        else if (fill_count >= pause_th)
            st_d.paused = 1'b1;                       // R5, R7, R8
        else if (fill_count <= resume_th)
            st_d.paused = 1'b0;                       // R6
        st_d.rts_n = ~sw_rts | (~use_dtr & st_d.paused);
        st_d.dtr_n = ~sw_dtr | ( use_dtr & st_d.paused);
    end

    // R1, R9: single register stage, reset deasserts both pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{paused: 1'b0, rts_n: 1'b1, dtr_n: 1'b1};
        else
            st_q <= st_d;
    end

    assign rts_n = st_q.rts_n;
    assign dtr_n = st_q.dtr_n;
endmodule

// File: rtl/rx_flow_ctrl_chk.sv
module rx_flow_ctrl_chk #(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fill_count,
    input logic             flow_en,
    input logic             use_dtr,
    input logic             sw_rts,
    input logic             sw_dtr,
    input logic             rts_n,
    input logic             dtr_n,
    input logic [CNT_W-1:0] pause_th,
    input logic [CNT_W-1:0] resume_th
);
    logic auto_on;
    logic seen_q = 1'b0;

    assign auto_on = flow_en & (use_dtr ? sw_dtr : sw_rts);

    always @(posedge clk) seen_q <= 1'b1;

    always @(negedge clk) begin
        if (seen_q && !rst_n)
            a_r1_reset_high: assert (rts_n && dtr_n)
                else $error("R1 pins not deasserted in reset");
    end

    a_r2_unmanaged_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            ($past(use_dtr) ? (rts_n == !$past(sw_rts)) : (dtr_n == !$past(sw_dtr))));

    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flow_en)) |->
            (rts_n == !$past(sw_rts)) && (dtr_n == !$past(sw_dtr)));

    a_r4_not_started: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flow_en) && !$past(auto_on)) |->
            ($past(use_dtr) ? dtr_n : rts_n));

    a_r5_pause_at_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(auto_on) && ($past(fill_count) >= $past(pause_th))) |->
            ($past(use_dtr) ? dtr_n : rts_n));

    a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(auto_on) && ($past(fill_count) < $past(pause_th)) &&
         ($past(fill_count) <= $past(resume_th))) |->
            !($past(use_dtr) ? dtr_n : rts_n));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(auto_on, 2) && $past(auto_on) &&
         ($past(use_dtr) == $past(use_dtr, 2)) &&
         ($past(fill_count) < $past(pause_th)) && ($past(fill_count) > $past(resume_th))) |->
            (($past(use_dtr) ? dtr_n : rts_n) == $past(use_dtr ? dtr_n : rts_n)));

    a_r7_thresh_order: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_th <= pause_th) && (pause_th <= CNT_W'(FIFO_DEPTH)));
endmodule

bind rx_flow_ctrl rx_flow_ctrl_chk #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_count(fill_count),
    .flow_en   (flow_en),
    .use_dtr   (use_dtr),
    .sw_rts    (sw_rts),
    .sw_dtr    (sw_dtr),
    .rts_n     (rts_n),
    .dtr_n     (dtr_n),
    .pause_th  (pause_th),
    .resume_th (resume_th)
);

// File: tb/rx_flow_ctrl_tb.sv
`timescale 1ns/1ps
module rx_flow_ctrl_tb;
    localparam int DEPTH = 64;
    localparam int STEP  = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] fill;
    logic [1:0] tsel;
    logic [1:0] tidx;
    logic [6:0] plvl;
    logic [3:0] hcode;
    logic       flow_en, use_dtr, sw_rts, sw_dtr;
    logic       rts_n, dtr_n;

    int checks = 0;
    int fails  = 0;
    bit m_paused = 1'b0;
    bit done = 1'b0;
    int tbl [3][4] = '{'{8, 16, 56, 60}, '{16, 32, 48, 56}, '{8, 16, 32, 56}};

    rx_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fill_count(fill), .table_sel(tsel),
        .trig_idx(tidx), .prog_level(plvl), .hyst_code(hcode),
        .flow_en(flow_en), .use_dtr(use_dtr), .sw_rts(sw_rts), .sw_dtr(sw_dtr),
        .rts_n(rts_n), .dtr_n(dtr_n)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            summary();
        end
    end

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b (fill=%0d tsel=%0d idx=%0d lvl=%0d code=%0d)",
                     req, got, exp, fill, tsel, tidx, plvl, hcode);
        end
    endtask

    task automatic thresholds(output int p, output int r);
        int h, lv;
        if (tsel == 2'd3) begin
            h  = STEP * int'(hcode);
            lv = (int'(plvl) > DEPTH) ? DEPTH : int'(plvl);
            p  = int'(plvl) + h;
            if (p > DEPTH) p = DEPTH;
            r  = lv - h;
            if (r < 0) r = 0;
        end else begin
            p = (tidx == 2'd3) ? DEPTH : tbl[int'(tsel)][int'(tidx) + 1];
            r = (tidx == 2'd0) ? 0 : tbl[int'(tsel)][int'(tidx) - 1];
        end
    endtask

    // One edge: advance the model with current inputs, then compare.
    task automatic step(input string tag);
        int p, r;
        bit auto_m, exp_r, exp_d;
        thresholds(p, r);
        auto_m = flow_en && (use_dtr ? sw_dtr : sw_rts);
        if (!auto_m)               m_paused = 1'b0;
        else if (int'(fill) >= p)  m_paused = 1'b1;
        else if (int'(fill) <= r)  m_paused = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_r = !sw_rts || (!use_dtr && m_paused);
        exp_d = !sw_dtr || ( use_dtr && m_paused);
        if (use_dtr) begin
            check(tag, dtr_n, exp_d);
            check("R2", rts_n, exp_r);
        end else begin
            check(tag, rts_n, exp_r);
            check("R2", dtr_n, exp_d);
        end
    endtask

    task automatic ramp(input string up_tag, input string dn_tag);
        for (int f = 0; f <= DEPTH; f++) begin
            fill = 7'(f);
            if (use_dtr) sw_rts = fill[1]; else sw_dtr = fill[1];
            step(up_tag);
        end
        for (int f = DEPTH; f >= 0; f--) begin
            fill = 7'(f);
            if (use_dtr) sw_rts = fill[1]; else sw_dtr = fill[1];
            step(dn_tag);
        end
    endtask

    initial begin
        rst_n = 1'b0; fill = '0; tsel = '0; tidx = '0; plvl = '0; hcode = '0;
        flow_en = 1'b0; use_dtr = 1'b0; sw_rts = 1'b1; sw_dtr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", rts_n, 1'b1);
        check("R1", dtr_n, 1'b1);
        rst_n = 1'b1;

        // R3: software bits pass straight through when automatic control is off
        for (int u = 0; u < 2; u++)
            for (int s = 0; s < 4; s++)
                for (int f = 0; f < 2; f++) begin
                    use_dtr = u[0]; sw_rts = s[0]; sw_dtr = s[1];
                    fill = f[0] ? 7'(DEPTH) : 7'd0;
                    step("R3");
                end

        // R4: enabled but not started, managed pin stays deasserted
        flow_en = 1'b1;
        for (int u = 0; u < 2; u++) begin
            use_dtr = u[0]; sw_rts = 1'b0; sw_dtr = 1'b0;
            for (int f = 0; f <= DEPTH; f++) begin
                fill = 7'(f);
                if (use_dtr) sw_rts = fill[0]; else sw_dtr = fill[0];
                step("R4");
            end
        end

        // R5, R6, R7: every fixed table entry, both pin selections
        for (int u = 0; u < 2; u++)
            for (int t = 0; t < 3; t++)
                for (int i = 0; i < 4; i++) begin
                    use_dtr = u[0]; tsel = 2'(t); tidx = 2'(i);
                    sw_rts = 1'b1; sw_dtr = 1'b1;
                    ramp((i == 3) ? "R7" : "R5", (i == 0) ? "R7" : "R6");
                end

        // R9: one-edge latency, table 0 entry 1 (pause 56, resume 8)
        use_dtr = 1'b0; tsel = 2'd0; tidx = 2'd1; sw_rts = 1'b1; sw_dtr = 1'b1;
        fill = 7'd0; step("R9");
        fill = 7'd56; #1; check("R9", rts_n, 1'b0);
        @(negedge clk); check("R9", rts_n, 1'b1);
        m_paused = 1'b1;
        fill = 7'd0; #1; check("R9", rts_n, 1'b1);
        @(negedge clk); check("R9", rts_n, 1'b0);
        m_paused = 1'b0;

        // R4 restart and R3 bypass while paused
        fill = 7'd60; step("R5");
        sw_rts = 1'b0; step("R4");
        fill = 7'd40; sw_rts = 1'b1; step("R4");
        fill = 7'd60; step("R5");
        flow_en = 1'b0; step("R3");
        flow_en = 1'b1; step("R5");

        // R8: programmable levels and bands
        tsel = 2'd3;
        for (int u = 0; u < 2; u++)
            for (int l = 0; l < 5; l++)
                for (int c = 0; c < 4; c++) begin
                    int lv_list [5] = '{0, 10, 32, 60, 64};
                    int cd_list [4] = '{0, 1, 5, 15};
                    use_dtr = u[0]; plvl = 7'(lv_list[l]); hcode = 4'(cd_list[c]);
                    sw_rts = 1'b1; sw_dtr = 1'b1;
                    ramp("R8", "R8");
                end

        done = 1'b1;
        summary();
    end
endmodule